// File: doc/BRIEF.md
# Pipelined Context-Adaptive Bin Decoder

This block decodes context-coded bins of a binary arithmetic code. Each request names a syntax-element class and a bin position within it. It also carries the current interval range and offset, which an external renormalizer supplies. From these the block derives a context-memory address. It splits the interval using the stored probability state and returns the decoded bin together with the unnormalized range and offset that follow from it.

Work is spread over two pipeline stages. In the first stage the context is read from a two-port memory. In the second stage the interval is split, the bin is decided and the updated context is written back. Because of this split, the read for the next bin overlaps the write-back of the current one. When back-to-back bins use the same context, the updated state is forwarded past the memory, so a full stream runs at one bin per cycle. A valid/ready pair at each end of the block lets the consumer stall both stages together.

On reset every context holds probability state 0 and most-probable symbol 0. Loading initial context values is handled elsewhere.

Top module: `ctx_bin_decoder`

## Requirements
- R1: The context address is `req_se * BINS_PER_SE + req_bin` (8 bins per class by default). Each address keeps its own state, independent of all others.
- R2: After reset, `bin_valid` is 0 and `req_ready` is 1. Every context starts at state 0 with most-probable symbol 0.
- R3: The LPS sub-range for state s and quarter q = range[7:6] is computed as follows. Start with P(0) = 16384 and form P(s+1) = (P(s) * 62427) >> 16. The sub-range is (P(s) * (288 + 64*q)) >> 15, raised to 6 if it would be smaller.
- R4: Let rM = range − rLPS. If offset < rM, the bin equals the most-probable symbol, the output range is rM and the offset passes through unchanged. The state then becomes min(s+1, 62).
- R5: If offset ≥ rM, the bin is the inverse of the most-probable symbol, the output range is rLPS and the output offset is offset − rM. The state becomes s − 1 − (s >> 2) for s > 0, and stays 0 when s = 0.
- R6: An LPS decoded at state 0 inverts the stored most-probable symbol.
- R7: A request accepted at a clock edge shows its result with `bin_valid` high from that edge until it is taken. With `out_ready` held high, one request is accepted on every cycle.
- R8: A bin that uses the same context as the bin immediately before it decodes with that bin's updated state.
- R9: While `bin_valid` is high and `out_ready` is low, `req_ready` is low and the bin outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bin request present |
| req_ready | output | 1 | Request accepted at this edge when both are high |
| req_se | input | 3 | Syntax-element class |
| req_bin | input | 3 | Bin position within the class |
| req_range | input | 9 | Current interval range (256..511) |
| req_offset | input | 9 | Current offset (below range) |
| out_ready | input | 1 | Consumer takes the bin result |
| bin_valid | output | 1 | Bin result present |
| bin_value | output | 1 | Decoded bin |
| bin_range | output | 9 | Range after the split, before renormalization |
| bin_offset | output | 9 | Offset after the split, before renormalization |

## Verification
The hardest case to reach is a request that reads a context while that same context is being written back. It occurs only when two accepted requests with the same address sit in adjacent cycles, and it matters only when the first of the two changed the state. The stimulus therefore includes long runs on a single context. In these runs, offsets near the top of the range force LPS decisions at state 0, which flip the symbol, and small offsets push the state upward. These runs are repeated with a randomly stalling consumer, so that forwarded values must also survive a hold.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
    localparam int RANGE_W   = 9;
    localparam int STATE_W   = 6;
    localparam int NUM_STATE = 64;
    localparam int TOP_STATE = 62;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               mps;
    } ctx_t;

    typedef logic [3:0][RANGE_W-1:0]        lps_row_t;
    typedef lps_row_t [NUM_STATE-1:0]       lps_tab_t;

    function automatic lps_tab_t build_lps_tab();
        lps_tab_t t;
        int p;
        int v;
        p = 16384;
        for (int s = 0; s < NUM_STATE; s++) begin
            for (int q = 0; q < 4; q++) begin
                v = (p * (288 + 64 * q)) >>> 15;
                if (v < 6) v = 6;
                t[s][q] = RANGE_W'(v);
            end
            p = (p * 62427) >>> 16;
        end
        return t;
    endfunction

    localparam lps_tab_t LPS_TAB = build_lps_tab();
endpackage

// File: rtl/cbd_ctx_mem.sv
module cbd_ctx_mem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 7,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q <= '0;
        end else begin
            if (wr_en) mem_q[wr_addr] <= wr_data;
            if (rd_en) rd_q <= mem_q[rd_addr];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/cbd_split.sv
module cbd_split
    import cbd_pkg::*;
(
    input  ctx_t               ctx_in,
    input  logic [RANGE_W-1:0] range_in,
    input  logic [RANGE_W-1:0] offset_in,
    output logic               bin_out,
    output logic [RANGE_W-1:0] range_out,
    output logic [RANGE_W-1:0] offset_out,
    output ctx_t               ctx_out
);
    logic [RANGE_W-1:0] r_lps;
    logic [RANGE_W-1:0] r_mps;
    logic [1:0]         quarter;

    always_comb begin
        quarter = range_in[7:6];
        r_lps   = LPS_TAB[ctx_in.state][quarter];
        r_mps   = range_in - r_lps;
        ctx_out = ctx_in;
        if (offset_in >= r_mps) begin
            bin_out    = ~ctx_in.mps;
            range_out  = r_lps;
            offset_out = offset_in - r_mps;
            if (ctx_in.state == '0) begin
                ctx_out.mps = ~ctx_in.mps;
            end else begin
                ctx_out.state = ctx_in.state - STATE_W'(1) - (ctx_in.state >> 2);
            end
        end else begin
            bin_out    = ctx_in.mps;
            range_out  = r_mps;
            offset_out = offset_in;
            if (ctx_in.state < STATE_W'(TOP_STATE))
                ctx_out.state = ctx_in.state + STATE_W'(1);
        end
    end
endmodule

// File: rtl/ctx_bin_decoder.sv
module ctx_bin_decoder
    import cbd_pkg::*;
#(
    parameter int SE_COUNT    = 8,
    parameter int BINS_PER_SE = 8,
    localparam int SE_W       = $clog2(SE_COUNT),
    localparam int BIN_W      = $clog2(BINS_PER_SE),
    localparam int DEPTH      = SE_COUNT * BINS_PER_SE,
    localparam int AW         = $clog2(DEPTH),
    localparam int CTX_W      = STATE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SE_W-1:0]    req_se,
    input  logic [BIN_W-1:0]   req_bin,
    input  logic [RANGE_W-1:0] req_range,
    input  logic [RANGE_W-1:0] req_offset,
    input  logic               out_ready,
    output logic               bin_valid,
    output logic               bin_value,
    output logic [RANGE_W-1:0] bin_range,
    output logic [RANGE_W-1:0] bin_offset
);
    typedef struct packed {
        logic               s1_valid;
        logic [AW-1:0]      s1_addr;
        logic [RANGE_W-1:0] s1_range;
        logic [RANGE_W-1:0] s1_offset;
        logic               fwd;
        ctx_t               fwd_ctx;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic             advance;
    logic [AW-1:0]    req_addr;
    logic [CTX_W-1:0] mem_rd;
    ctx_t             cur_ctx;
    ctx_t             upd_ctx;

    assign req_addr = AW'(req_se) * AW'(BINS_PER_SE) + AW'(req_bin);
    assign advance  = !pipe_q.s1_valid || out_ready;
    assign cur_ctx  = pipe_q.fwd ? pipe_q.fwd_ctx : ctx_t'(mem_rd);

    cbd_ctx_mem #(.DEPTH(DEPTH), .WIDTH(CTX_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pipe_q.s1_valid && advance),
        .wr_addr (pipe_q.s1_addr),
        .wr_data (CTX_W'(upd_ctx)),
        .rd_en   (advance && req_valid),
        .rd_addr (req_addr),
        .rd_data (mem_rd)
    );

    cbd_split u_split (
        .ctx_in     (cur_ctx),
        .range_in   (pipe_q.s1_range),
        .offset_in  (pipe_q.s1_offset),
        .bin_out    (bin_value),
        .range_out  (bin_range),
        .offset_out (bin_offset),
        .ctx_out    (upd_ctx)
    );

    always_comb begin
        pipe_d = pipe_q;
        if (advance) begin
            pipe_d.s1_valid  = req_valid;
            pipe_d.s1_addr   = req_addr;
            pipe_d.s1_range  = req_range;
            pipe_d.s1_offset = req_offset;
            pipe_d.fwd       = req_valid && pipe_q.s1_valid && (req_addr == pipe_q.s1_addr);
            pipe_d.fwd_ctx   = upd_ctx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign req_ready = advance;
    assign bin_valid = pipe_q.s1_valid;
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [8:0] req_range,
    input logic       out_ready,
    input logic       bin_valid,
    input logic       bin_value,
    input logic [8:0] bin_range,
    input logic [8:0] bin_offset
);
    a_r7_accept_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bin_valid);

    a_r4_range_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bin_range < $past(req_range)) && (bin_range != 0));

    a_r5_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        bin_valid |-> (bin_offset < bin_range));

    a_r9_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_valid && !out_ready) |-> !req_ready);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_valid && !out_ready) |=> bin_valid && $stable(bin_value)
                                      && $stable(bin_range) && $stable(bin_offset));
endmodule

bind ctx_bin_decoder cbd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_range  (req_range),
    .out_ready  (out_ready),
    .bin_valid  (bin_valid),
    .bin_value  (bin_value),
    .bin_range  (bin_range),
    .bin_offset (bin_offset)
);

// File: tb/ctx_bin_decoder_bench.sv
module ctx_bin_decoder_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       req_valid = 0;
    logic       req_ready;
    logic [2:0] req_se = 0;
    logic [2:0] req_bin = 0;
    logic [8:0] req_range = 9'd256;
    logic [8:0] req_offset = 0;
    logic       out_ready = 1;
    logic       bin_valid;
    logic       bin_value;
    logic [8:0] bin_range;
    logic [8:0] bin_offset;

    ctx_bin_decoder u_ctx_bin_decoder (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        bit    b;
        int    rng;
        int    off;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    st[64];
    bit    mp[64];
    bit    stall_mode = 0;
    bit    done = 0;

    always @(posedge clk) cyc++;
    always @(negedge clk) out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;

    function automatic int rlps(int s, int rng);
        int p = 16384;
        int v;
        for (int i = 0; i < s; i++) p = (p * 62427) >>> 16;
        v = (p * (288 + 64 * ((rng >> 6) & 3))) >>> 15;
        return (v < 6) ? 6 : v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic send(input int se, input int bn, input int rng, input int off, input string tag);
        exp_t e;
        int a, s, rl, rm;
        @(negedge clk);
        req_valid = 1; req_se = 3'(se); req_bin = 3'(bn);
        req_range = 9'(rng); req_offset = 9'(off);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        a = se * 8 + bn; s = st[a]; rl = rlps(s, rng); rm = rng - rl;
        e.tag = tag;
        if (off >= rm) begin
            e.b = !mp[a]; e.rng = rl; e.off = off - rm;
            if (s == 0) mp[a] = !mp[a];
            else st[a] = s - 1 - (s >> 2);
        end else begin
            e.b = mp[a]; e.rng = rm; e.off = off;
            st[a] = (s < 62) ? s + 1 : 62;
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); req_valid = 0; end
    endtask

    task automatic rand_send(input int se, input int bn, input string tag);
        int rng = 256 + ($urandom % 256);
        send(se, bn, rng, $urandom % rng, tag);
    endtask

    // monitor / scoreboard
    initial begin
        bit pstall = 0; bit pb = 0; int pr = 0; int po = 0;
        exp_t e;
        forever begin
            @(negedge clk); #2;
            if (rst_n) begin
                if (pstall) check(bin_valid && bin_value == pb && bin_range == pr && bin_offset == po,
                                  "R9 hold", bin_range, pr);
                if (bin_valid && !out_ready) check(!req_ready, "R9 ready", req_ready, 0);
                if (bin_valid && out_ready) begin
                    if (sb.size() == 0) check(0, "R7 unexpected bin", 1, 0);
                    else begin
                        e = sb.pop_front();
                        check(bin_value == e.b, {e.tag, " bin"}, bin_value, e.b);
                        check(bin_range == e.rng, {e.tag, " range"}, bin_range, e.rng);
                        check(bin_offset == e.off, {e.tag, " offset"}, bin_offset, e.off);
                    end
                end
                pstall = bin_valid && !out_ready;
                pb = bin_value; pr = bin_range; po = bin_offset;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int t0;
        for (int i = 0; i < 64; i++) begin st[i] = 0; mp[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #2;
        check(bin_valid == 0, "R2 valid after reset", bin_valid, 0);
        check(req_ready == 1, "R2 ready after reset", req_ready, 1);

        // R2 / R6: LPS at state 0 flips MPS, next LPS flips back
        send(0, 0, 300, 299, "R6");
        idle(2);
        send(0, 0, 300, 299, "R6");
        idle(2);
        // R4 MPS path from reset state, R3 table at several quarters
        send(1, 2, 256, 0, "R4");
        send(2, 3, 320, 10, "R3");
        send(3, 4, 400, 5, "R3");
        send(4, 5, 480, 1, "R3");
        idle(3);
        // R8: back-to-back on one context, MPS runs then LPS
        for (int i = 0; i < 20; i++) send(5, 1, 256 + i * 12, 0, "R8");
        for (int i = 0; i < 6; i++) send(5, 1, 500, 499, "R8");
        for (int i = 0; i < 6; i++) send(5, 1, 450, 449, "R5");
        idle(3);
        // R1: neighbouring addresses stay independent
        for (int i = 0; i < 8; i++) send(6, i, 300, 0, "R1");
        for (int i = 0; i < 8; i++) send(6, 7 - i, 300, 299, "R1");
        idle(3);
        // R7: burst with the consumer always ready
        t0 = cyc;
        for (int i = 0; i < 16; i++) rand_send(i % 8, (i * 3) % 8, "R7");
        check(cyc - t0 == 16, "R7 throughput cycles", cyc - t0, 16);
        idle(3);
        // random mix including same-context pairs
        for (int i = 0; i < 300; i++) begin
            if (i % 4 == 0) begin rand_send(7, 0, "R8"); rand_send(7, 0, "R8"); end
            else rand_send($urandom % 8, $urandom % 8, "R5");
        end
        idle(3);
        // R9: stalling consumer with forwarding pressure
        stall_mode = 1;
        for (int i = 0; i < 300; i++) begin
            if (i % 3 == 0) rand_send(2, 2, "R9");
            else rand_send($urandom % 8, $urandom % 8, "R9");
        end
        idle(2);
        stall_mode = 0;
        idle(6);
        check(sb.size() == 0, "R7 all results delivered", sb.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule